// File: doc/BRIEF.md
# Descriptor-Driven DMA Channel Engine

This block runs basic-mode copies for a small multi-channel DMA controller. Each channel's control descriptor sits in system memory, in a table whose base is aligned to 256 bytes for up to 8 channels or 512 bytes for up to 16. When an enabled channel raises its request, the engine forms that channel's descriptor address from the table base, the channel's primary/alternate select, the channel index and the field index. It then reads the three descriptor words it needs and moves exactly one item of byte, halfword or word size from source to destination.

Item addresses are counted backwards from the end pointers held in the descriptor. The remaining-count field sets how far back the engine steps. After each item the engine writes the control word back with that count reduced by one. After the final item it writes the word back with the cycle-mode field cleared, so the descriptor becomes invalid, and it pulses a one-cycle done flag for the channel. Requests are level-sensitive. A requester holds its line high and is served one item per grant, with the lowest-numbered enabled requester winning each grant. The memory port is a simple master with separate read and write strobes. Read data comes back on the cycle after the read strobe.

Top module: `dma_desc_engine`

## Requirements
- R1: While reset is held and after it is released with no requests, `mem_rd`, `mem_wr` and `ch_done` are all zero.
- R2: The descriptor address is formed as follows. Bits 1:0 are zero. Bits 3:2 hold the field index. The channel number sits above the field index (bits 6:4 with 8 channels, bits 7:4 with 16). The alternate select bit sits just above the channel number (bit 7 with 8 channels, bit 8 with 16). All higher bits come from `table_base`.
- R3: Each grant reads descriptor fields in this order: field 0 (source end pointer), field 1 (destination end pointer), field 2 (control word). Read data is taken on the cycle after each read strobe.
- R4: The control word layout is: bits 1:0 cycle mode (1 = basic, 0 = invalid); bits 13:4 remaining count, written as N minus 1; bits 17:16 item size (0 byte, 1 halfword, 2 word); bit 20 source increments; bit 21 destination increments. Each item is read from and written to its end pointer minus (remaining count times increment). The increment is the item size in bytes, or zero when that side's increment bit is clear.
- R5: Each grant moves exactly one item. The engine reads the source, and on the next cycle writes the read data to the destination. `mem_size` carries the item-size code during the data transfer and the word code 2 for descriptor accesses.
- R6: After each item the control word is written back to field 2. When items remain, the count is one lower. After the last item, the count is zero and the cycle-mode field is 0. All other bits are kept.
- R7: `ch_done` pulses for exactly one cycle, on the granted channel only, in the cycle after the final write-back. An item that is not the last gives no pulse.
- R8: A request on a channel whose enable is low causes no memory access and no done pulse.
- R9: When several enabled channels request in the same cycle, the lowest channel number is served first.
- R10: If the fetched control word has a cycle mode other than basic, or has size code 3, no data is moved, no write-back occurs and no done pulse is given.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| table_base | input | ADDR_W | Descriptor table base; only the bits above the table offset are used |
| ch_enable | input | NUM_CH | Per-channel enable |
| ch_alt_sel | input | NUM_CH | Per-channel list select, 1 = alternate descriptor list |
| ch_req | input | NUM_CH | Per-channel level request, one item per grant |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_size | output | 2 | Access size code: 0 byte, 1 halfword, 2 word |
| mem_wdata | output | 32 | Write data, with the item in the low lanes |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_rd` |
| ch_done | output | NUM_CH | One-cycle completion pulse per channel |

## Verification
The copy function is driven through a set of descriptors that vary the channel, the list select, the item size, the count and the pairing of increments. The pairings include both sides incrementing, a fixed source feeding an incrementing destination, and an incrementing source draining into a fixed destination. A single-item case is also included. Comparing the whole memory image against a bench-computed copy separates errors in the backward address arithmetic, the step per size and the handling of zero increments. It also shows whether a fixed destination ends up holding the last item rather than the first. Other directed cases check the following: a disabled requester, two requesters arriving together (which shows the service order), and descriptors with an invalid cycle mode or an illegal size (which show that nothing moves and nothing is written back).

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

    // control word layout
    localparam int CTL_MODE_LSB = 0;
    localparam int CTL_CNT_LSB  = 4;
    localparam int CTL_CNT_W    = 10;
    localparam int CTL_SIZE_LSB = 16;
    localparam int CTL_SINC_BIT = 20;
    localparam int CTL_DINC_BIT = 21;

    localparam logic [1:0] MODE_OFF   = 2'd0;
    localparam logic [1:0] MODE_BASIC = 2'd1;
    localparam logic [1:0] SIZE_WORD  = 2'd2;
    localparam logic [1:0] SIZE_BAD   = 2'd3;

    // descriptor field indices
    localparam logic [1:0] FLD_SRC  = 2'd0;
    localparam logic [1:0] FLD_DST  = 2'd1;
    localparam logic [1:0] FLD_CTRL = 2'd2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FSRC,
        S_FDST,
        S_FCTL,
        S_CHK,
        S_XRD,
        S_XWR,
        S_WB
    } eng_st_e;

    function automatic logic [1:0] ctl_mode(input logic [31:0] c);
        return c[CTL_MODE_LSB +: 2];
    endfunction

    function automatic logic [1:0] ctl_size(input logic [31:0] c);
        return c[CTL_SIZE_LSB +: 2];
    endfunction

    function automatic logic [CTL_CNT_W-1:0] ctl_cnt(input logic [31:0] c);
        return c[CTL_CNT_LSB +: CTL_CNT_W];
    endfunction

endpackage

// File: rtl/dma_pick_lowest.sv
module dma_pick_lowest #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
    import dma_eng_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CH_W   = 3
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [CH_W-1:0]   ch,
    input  logic              alt,
    input  logic [1:0]        field,
    input  logic [31:0]       ctrl,
    input  logic [ADDR_W-1:0] src_end,
    input  logic [ADDR_W-1:0] dst_end,
    output logic [ADDR_W-1:0] desc_addr,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr
);

    localparam int OFS_W = CH_W + 5;

    logic [ADDR_W-1:0] step;

    always_comb begin
        desc_addr = {base[ADDR_W-1:OFS_W], alt, ch, field, 2'b00};
        step      = ADDR_W'(ctl_cnt(ctrl)) << ctl_size(ctrl);
        src_addr  = ctrl[CTL_SINC_BIT] ? (src_end - step) : src_end;
        dst_addr  = ctrl[CTL_DINC_BIT] ? (dst_end - step) : dst_end;
    end

endmodule

// File: rtl/dma_desc_engine.sv
module dma_desc_engine
    import dma_eng_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] table_base,
    input  logic [NUM_CH-1:0] ch_enable,
    input  logic [NUM_CH-1:0] ch_alt_sel,
    input  logic [NUM_CH-1:0] ch_req,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic [NUM_CH-1:0] ch_done
);

    localparam int CH_W = (NUM_CH <= 8) ? 3 : 4;

    typedef struct packed {
        eng_st_e           st;
        logic [CH_W-1:0]   ch;
        logic              alt;
        logic [ADDR_W-1:0] src_end;
        logic [ADDR_W-1:0] dst_end;
        logic [31:0]       ctrl;
        logic [NUM_CH-1:0] done;
    } eng_t;

    eng_t d, q;

    logic              pick_any;
    logic [CH_W-1:0]   pick_idx;
    logic [1:0]        field;
    logic [ADDR_W-1:0] desc_addr, src_addr, dst_addr;
    logic [31:0]       wb_word;
    logic              last_item;

    dma_pick_lowest #(.N(NUM_CH), .IDX_W(CH_W)) u_pick (
        .req (ch_req & ch_enable),
        .any (pick_any),
        .idx (pick_idx)
    );

    dma_addr_gen #(.ADDR_W(ADDR_W), .CH_W(CH_W)) u_agen (
        .base      (table_base),
        .ch        (q.ch),
        .alt       (q.alt),
        .field     (field),
        .ctrl      (q.ctrl),
        .src_end   (q.src_end),
        .dst_end   (q.dst_end),
        .desc_addr (desc_addr),
        .src_addr  (src_addr),
        .dst_addr  (dst_addr)
    );

    always_comb begin
        last_item = (ctl_cnt(q.ctrl) == '0);
        wb_word   = q.ctrl;
        if (last_item) begin
            wb_word[CTL_MODE_LSB +: 2] = MODE_OFF;
        end else begin
            wb_word[CTL_CNT_LSB +: CTL_CNT_W] = ctl_cnt(q.ctrl) - 1'b1;
        end
        case (q.st)
            S_FDST:       field = FLD_DST;
            S_FCTL, S_WB: field = FLD_CTRL;
            default:      field = FLD_SRC;
        endcase
    end

    always_comb begin
        d      = q;
        d.done = '0;
        case (q.st)
            S_IDLE: begin
                if (pick_any) begin
                    d.ch  = pick_idx;
                    d.alt = ch_alt_sel[pick_idx];
                    d.st  = S_FSRC;
                end
            end
            S_FSRC: d.st = S_FDST;
            S_FDST: begin
                d.src_end = mem_rdata[ADDR_W-1:0];
                d.st      = S_FCTL;
            end
            S_FCTL: begin
                d.dst_end = mem_rdata[ADDR_W-1:0];
                d.st      = S_CHK;
            end
            S_CHK: begin
                d.ctrl = mem_rdata;
                if (ctl_mode(mem_rdata) == MODE_BASIC && ctl_size(mem_rdata) != SIZE_BAD)
                    d.st = S_XRD;
                else
                    d.st = S_IDLE;
            end
            S_XRD: d.st = S_XWR;
            S_XWR: d.st = S_WB;
            S_WB: begin
                d.st = S_IDLE;
                if (last_item) d.done[q.ch] = 1'b1;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        mem_rd    = (q.st == S_FSRC) || (q.st == S_FDST) || (q.st == S_FCTL) || (q.st == S_XRD);
        mem_wr    = (q.st == S_XWR) || (q.st == S_WB);
        mem_size  = SIZE_WORD;
        mem_wdata = '0;
        mem_addr  = desc_addr;
        case (q.st)
            S_XRD: begin
                mem_addr = src_addr;
                mem_size = ctl_size(q.ctrl);
            end
            S_XWR: begin
                mem_addr  = dst_addr;
                mem_size  = ctl_size(q.ctrl);
                mem_wdata = mem_rdata;
            end
            S_WB: mem_wdata = wb_word;
            default: ;
        endcase
        ch_done = q.done;
    end

    // R8
    ignore_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_IDLE && (ch_req & ch_enable) == '0) |=> !mem_rd);

    // R7
    done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_done));

    // R7
    done_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_done) |-> $past(mem_wr));

    // R5
    no_rd_wr_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R5
    legal_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> (mem_size != SIZE_BAD));

    // R10
    invalid_desc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_CHK && (ctl_mode(mem_rdata) != MODE_BASIC || ctl_size(mem_rdata) == SIZE_BAD))
        |=> (!mem_wr && !mem_rd));

endmodule

// File: tb/sim_dma_desc_engine.sv
module sim_dma_desc_engine;

    localparam int NCH = 8;
    localparam logic [31:0] TBASE = 32'hABCD_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NCH-1:0] ch_enable = '0, ch_alt_sel = '0, ch_req = '0;
    logic        mem_rd, mem_wr;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic [1:0]  mem_size;
    logic [NCH-1:0] ch_done;

    always #2 clk = ~clk;

    dma_desc_engine #(.NUM_CH(NCH), .ADDR_W(32)) u0 (
        .clk, .rst_n, .table_base(TBASE), .ch_enable, .ch_alt_sel, .ch_req,
        .mem_rd, .mem_wr, .mem_addr, .mem_size, .mem_wdata, .mem_rdata, .ch_done
    );

    logic [7:0] mem [0:1023];
    logic [7:0] exp_mem [0:1023];

    // memory model: one-cycle read latency
    always @(posedge clk) begin
        if (mem_rd) begin
            for (int b = 0; b < 4; b++)
                mem_rdata[b*8 +: 8] <= mem[(int'(mem_addr[9:0]) + b) & 1023];
        end
        if (mem_wr) begin
            for (int b = 0; b < (1 << mem_size); b++)
                mem[(int'(mem_addr[9:0]) + b) & 1023] <= mem_wdata[b*8 +: 8];
        end
    end

    int tests = 0, fails = 0, cyc = 0;
    int done_cnt [NCH];
    int done_log [8];
    int done_n = 0;
    int rd_n = 0, data_wr_cnt = 0;
    logic [31:0] rd_log [3];
    logic [1:0]  last_size;

    initial for (int i = 0; i < NCH; i++) done_cnt[i] = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rd) begin
                if (rd_n < 3) rd_log[rd_n] = mem_addr;
                rd_n++;
            end
            if (mem_wr && mem_addr[9:8] != 2'b00) begin
                data_wr_cnt++;
                last_size = mem_size;
            end
            for (int i = 0; i < NCH; i++) begin
                if (ch_done[i]) begin
                    done_cnt[i]++;
                    if (done_n < 8) done_log[done_n] = i;
                    done_n++;
                end
            end
        end
    end

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            tests++; fails++;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] ex);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", rq, act, ex);
        end
    endtask

    function automatic logic [31:0] rd32(input int a);
        return {mem[(a+3)&1023], mem[(a+2)&1023], mem[(a+1)&1023], mem[a&1023]};
    endfunction

    task automatic wr32(input int a, input logic [31:0] v);
        for (int b = 0; b < 4; b++) mem[(a + b) & 1023] = v[b*8 +: 8];
    endtask

    function automatic logic [31:0] mk_ctrl(input int mode, input int n, input int size, input int si, input int di);
        return 32'(mode) | (32'(n - 1) << 4) | (32'(size) << 16) | (32'(si) << 20) | (32'(di) << 21);
    endfunction

    task automatic put_desc(input int ch, input int alt, input int se, input int de, input logic [31:0] ctl);
        int lo = alt * 128 + ch * 16;
        wr32(lo, TBASE | 32'(se));
        wr32(lo + 4, TBASE | 32'(de));
        wr32(lo + 8, ctl);
        wr32(lo + 12, 32'h0);
    endtask

    task automatic clear_mon();
        rd_n = 0; data_wr_cnt = 0; done_n = 0;
    endtask

    typedef struct packed {
        logic [3:0]  ch;
        logic        alt;
        logic [1:0]  size;
        logic        si;
        logic        di;
        logic [10:0] n;
        logic [15:0] se;
        logic [15:0] de;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{4'd0, 1'b0, 2'd2, 1'b1, 1'b1, 11'd4, 16'h010C, 16'h020C},
        '{4'd3, 1'b1, 2'd0, 1'b0, 1'b1, 11'd5, 16'h0140, 16'h0224},
        '{4'd7, 1'b0, 2'd1, 1'b1, 1'b0, 11'd3, 16'h0164, 16'h02F0},
        '{4'd5, 1'b1, 2'd2, 1'b1, 1'b1, 11'd1, 16'h0180, 16'h0300},
        '{4'd2, 1'b0, 2'd1, 1'b1, 1'b1, 11'd6, 16'h01AA, 16'h030A}
    };

    task automatic run_vec(input vec_t v);
        int ch = int'(v.ch), n = int'(v.n), sz = int'(v.size);
        int lo = int'(v.alt) * 128 + ch * 16;
        int sstep = v.si ? (1 << sz) : 0;
        int dstep = v.di ? (1 << sz) : 0;
        int d0 = done_cnt[ch];
        int bad = 0, bad_at = 0;
        logic [31:0] ctl = mk_ctrl(1, n, sz, int'(v.si), int'(v.di));
        for (int i = 256; i < 1024; i++) mem[i] = 8'(i * 7 + n);
        put_desc(ch, int'(v.alt), int'(v.se), int'(v.de), ctl);
        for (int i = 0; i < 1024; i++) exp_mem[i] = mem[i];
        for (int k = 0; k < n; k++) begin
            int sa = int'(v.se) - (n - 1 - k) * sstep;
            int da = int'(v.de) - (n - 1 - k) * dstep;
            for (int b = 0; b < (1 << sz); b++) exp_mem[(da + b) & 1023] = exp_mem[(sa + b) & 1023];
        end
        begin
            logic [31:0] fin = ctl & ~32'h3 & ~(32'h3FF << 4);
            for (int b = 0; b < 4; b++) exp_mem[lo + 8 + b] = fin[b*8 +: 8];
        end
        clear_mon();
        ch_alt_sel[ch] = v.alt;
        ch_enable[ch]  = 1'b1;
        ch_req[ch]     = 1'b1;
        for (int t = 0; t < 600 && done_cnt[ch] == d0; t++) @(negedge clk);
        ch_req[ch] = 1'b0;
        repeat (4) @(negedge clk);
        ch_enable[ch] = 1'b0;
        // R2: descriptor address including list select
        chk(rd_log[0] == (TBASE | 32'(lo)), "R2 desc addr", rd_log[0], TBASE | 32'(lo));
        // R3: field order
        chk(rd_log[1] == (TBASE | 32'(lo + 4)) && rd_log[2] == (TBASE | 32'(lo + 8)),
            "R3 field order", rd_log[2], TBASE | 32'(lo + 8));
        // R4: backward addressing, whole memory image
        for (int i = 256; i < 1024; i++) if (mem[i] !== exp_mem[i] && bad == 0) begin bad = 1; bad_at = i; end
        chk(bad == 0, "R4 data image", 32'(mem[bad_at]), 32'(exp_mem[bad_at]));
        // R6: final write-back
        chk(rd32(lo + 8) == {exp_mem[lo+11], exp_mem[lo+10], exp_mem[lo+9], exp_mem[lo+8]},
            "R6 ctrl writeback", rd32(lo + 8), {exp_mem[lo+11], exp_mem[lo+10], exp_mem[lo+9], exp_mem[lo+8]});
        // R5: one item per grant and size on bus
        chk(data_wr_cnt == n, "R5 item count", 32'(data_wr_cnt), 32'(n));
        chk(last_size == v.size, "R5 size code", 32'(last_size), 32'(v.size));
        // R7: single done pulse
        chk(done_cnt[ch] == d0 + 1 && done_n == 1, "R7 done pulse", 32'(done_cnt[ch] - d0), 32'd1);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1: idle during reset
        chk(!mem_rd && !mem_wr && ch_done == '0, "R1 reset idle", {30'd0, mem_rd, mem_wr}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!mem_rd && !mem_wr && ch_done == '0 && rd_n == 0, "R1 after reset", 32'(rd_n), 32'd0);

        for (int v = 0; v < 5; v++) run_vec(VECS[v]);

        // R6: intermediate write-back decrements count
        begin
            logic [31:0] c = mk_ctrl(1, 3, 2, 1, 1);
            put_desc(1, 0, 16'h0108, 16'h0208, c);
            clear_mon();
            ch_enable[1] = 1'b1;
            ch_req[1] = 1'b1;
            @(negedge clk);
            ch_req[1] = 1'b0;
            repeat (12) @(negedge clk);
            chk(rd32(24) == mk_ctrl(1, 2, 2, 1, 1), "R6 count decrement", rd32(24), mk_ctrl(1, 2, 2, 1, 1));
            chk(done_n == 0, "R7 no done mid-run", 32'(done_n), 32'd0);
            ch_enable[1] = 1'b0;
        end

        // R8: disabled channel ignored
        begin
            logic [31:0] c = mk_ctrl(1, 2, 0, 1, 1);
            put_desc(6, 0, 16'h0110, 16'h0210, c);
            clear_mon();
            ch_req[6] = 1'b1;
            repeat (30) @(negedge clk);
            ch_req[6] = 1'b0;
            chk(rd_n == 0 && data_wr_cnt == 0 && done_n == 0, "R8 disabled ignored", 32'(rd_n + data_wr_cnt), 32'd0);
            chk(rd32(96 + 8) == c, "R8 desc untouched", rd32(104), c);
        end

        // R9: lowest channel first
        begin
            put_desc(1, 0, 16'h0120, 16'h0220, mk_ctrl(1, 1, 2, 1, 1));
            put_desc(4, 0, 16'h0130, 16'h0230, mk_ctrl(1, 1, 2, 1, 1));
            clear_mon();
            ch_alt_sel = '0;
            ch_enable[1] = 1'b1; ch_enable[4] = 1'b1;
            ch_req[1] = 1'b1; ch_req[4] = 1'b1;
            for (int t = 0; t < 100 && done_n < 2; t++) begin
                @(negedge clk);
                for (int i = 0; i < NCH; i++) if (ch_done[i]) ch_req[i] = 1'b0;
            end
            ch_req = '0; ch_enable = '0;
            chk(rd_log[0] == (TBASE | 32'h10), "R9 first grant", rd_log[0], TBASE | 32'h10);
            chk(done_n == 2 && done_log[0] == 1 && done_log[1] == 4, "R9 done order", 32'(done_log[0]), 32'd1);
        end

        // R10: invalid mode and illegal size
        for (int m = 0; m < 2; m++) begin
            logic [31:0] c = (m == 0) ? mk_ctrl(0, 2, 2, 1, 1) : mk_ctrl(1, 2, 3, 1, 1);
            put_desc(2, 0, 16'h0140, 16'h0240, c);
            repeat (2) @(negedge clk);
            clear_mon();
            ch_enable[2] = 1'b1;
            ch_req[2] = 1'b1;
            @(negedge clk);
            ch_req[2] = 1'b0;
            repeat (15) @(negedge clk);
            ch_enable[2] = 1'b0;
            chk(data_wr_cnt == 0 && done_n == 0, "R10 nothing moved", 32'(data_wr_cnt + done_n), 32'd0);
            chk(rd32(40) == c, "R10 no writeback", rd32(40), c);
        end

        summary();
        $finish;
    end

endmodule